// File: doc/BRIEF.md
# Shared-Store Frame Pattern Generator

The generator produces test streams that look like the multiplexed frame output of a pair of detector readout chips. Six virtual channels share one frame-pattern store. Each channel walks a looping list of frame pointers that belongs only to it. Every frame starts with a short digital header and continues with one sample per detector strip.

The shared store is read once per base-clock cycle. The base clock runs at six times the per-channel sample rate, and each channel owns one fixed read slot. The six per-channel streams are joined in even/odd pairs into three streams at twice the channel rate. Each of the three streams then passes through a delay line with a programmable depth. A host write port can rewrite the pattern store and every pointer list while generation is running.

All three rates live in one clock domain. The base cycle counter stands in for the clock enables of the slower rates. The header levels come from configuration inputs. Defaults are scaled down to keep elaboration small. The design scales to 233 frames and 1024 pointer entries through its parameters.

Top module: `frame_pattern_gen`

## Requirements
- R1: A slot counter runs 0..N_CH-1 on every base clock and wraps to 0, and is 0 in the first cycle after reset. In slot c, channel c reads the shared store once, so each channel yields one sample every N_CH cycles.
- R2: A frame is HDR_LEN header samples followed by N_STRIPS strip samples. Header sample i is `hdr_hi` if `hdr_bits[i]` is 1 and `hdr_lo` otherwise. Strip sample j of frame f is pattern word f*N_STRIPS+j.
- R3: Each channel has a pointer list of PTR_DEPTH entries. It moves to the next entry once per frame and returns to entry 0 after the last entry.
- R4: The frame index is taken from the pointer list only at the first sample of a frame. A pointer write during a frame does not change the frame that is already playing.
- R5: A pointer value of N_FRAMES or more selects frame 0.
- R6: Output p carries channel 2p and channel 2p+1 in turn. Each channel's sample is held for N_CH/2 cycles. New values appear after the clock edges that end slot 1 and slot 1+N_CH/2.
- R7: With zero delay, the sample that channel 2p reads in period k appears on output p after the edge that ends slot 1 of period k+1. The matching odd-channel sample follows N_CH/2 cycles later.
- R8: Field p of `dly_cfg` (bits [DLY_W*p+DLY_W-1 : DLY_W*p]) delays output p by that many half-period steps, from 0 to MAX_DLY. Larger values act as MAX_DLY. Before any history exists, a delayed output shows 0.
- R9: A host write with `wr_tgt`=0 stores `wr_data` at pattern address `wr_addr`. A write with `wr_tgt`=c+1 stores the low bits of `wr_data` at entry `wr_addr` of the pointer list of channel c. Writes take effect at the clock edge, including during reset and while running. A read in the same cycle returns the old word.
- R10: While reset is asserted, all outputs are 0 and every channel is at pointer entry 0 and sample 0.
- R11: Output p occupies bits [12p+11:12p] of `out_codes` as a 12-bit DAC code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, N_CH times the channel sample rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_tgt | input | TGT_W | 0 = pattern store, c+1 = pointer list of channel c |
| wr_addr | input | ADDR_W | Word or entry address |
| wr_data | input | 12 | Pattern code or pointer value in the low bits |
| hdr_hi | input | 12 | Code for a header 1 |
| hdr_lo | input | 12 | Code for a header 0 |
| hdr_bits | input | HDR_LEN | Header bit pattern, bit i for header sample i |
| dly_cfg | input | N_OUT*DLY_W | Per-output delay in steps |
| out_codes | output | N_OUT*12 | Delayed interleaved DAC codes |

## Verification
Two functions can land in the same cycle. The first case is a host write to the very pattern word or pointer entry that a channel reads in its slot. The second is a pointer rewrite on the edge where a channel starts a new frame. The bench provokes both with a long burst of back-to-back random writes into small stores, so collisions at frame starts and on live words happen many times. Its cycle-exact model applies the read-before-write order, and any difference shows up as a wrong code on an output in that cycle.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
    localparam int DAC_W = 12;
    typedef logic [DAC_W-1:0] dac_t;

    // Kind of sample fetched in a read slot.
    typedef enum logic [1:0] {
        SK_NONE   = 2'd0,
        SK_HDR_HI = 2'd1,
        SK_HDR_LO = 2'd2,
        SK_STRIP  = 2'd3
    } smp_kind_e;

    function automatic int clamp_dly(input int v, input int mx);
        return (v > mx) ? mx : v;
    endfunction
endpackage

// File: rtl/fpg_seq.sv
module fpg_seq import fpg_pkg::*; #(
    parameter int N_CH      = 6,
    parameter int N_FRAMES  = 16,
    parameter int N_STRIPS  = 128,
    parameter int HDR_LEN   = 12,
    parameter int PTR_DEPTH = 256,
    localparam int SLOT_W    = $clog2(N_CH),
    localparam int FRAME_LEN = HDR_LEN + N_STRIPS,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int PTR_AW    = $clog2(PTR_DEPTH),
    localparam int PV_W      = $clog2(N_FRAMES + 1),
    localparam int FI_W      = $clog2(N_FRAMES),
    localparam int PAT_AW    = $clog2(N_FRAMES * N_STRIPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_we,
    input  logic [SLOT_W-1:0] ptr_ch,
    input  logic [PTR_AW-1:0] ptr_addr,
    input  logic [PV_W-1:0]   ptr_val,
    input  logic [HDR_LEN-1:0] hdr_bits,
    output logic [SLOT_W-1:0] slot,
    output smp_kind_e         rd_kind,
    output logic [PAT_AW-1:0] rd_addr
);
    logic [PV_W-1:0]   ptr_mem [N_CH][PTR_DEPTH];
    logic [POS_W-1:0]  pos     [N_CH];
    logic [PTR_AW-1:0] pidx    [N_CH];
    logic [FI_W-1:0]   frame_q [N_CH];

    logic [POS_W-1:0] cur_pos;
    logic [PV_W-1:0]  raw;
    logic [FI_W-1:0]  fetched, cur_frame;
    logic             hdr_one;

    // Pointer lists: written by the host, read asynchronously (read-first at the edge).
    always_ff @(posedge clk) begin
        for (int c = 0; c < N_CH; c++) begin
            if (ptr_we && ptr_ch == SLOT_W'(c))
                ptr_mem[c][ptr_addr] <= ptr_val;
        end
    end

    always_comb begin
        cur_pos   = pos[slot];
        raw       = ptr_mem[slot][pidx[slot]];
        fetched   = (int'(raw) >= N_FRAMES) ? '0 : raw[FI_W-1:0];
        cur_frame = (cur_pos == '0) ? fetched : frame_q[slot];
        hdr_one   = 1'b0;
        for (int i = 0; i < HDR_LEN; i++)
            if (int'(cur_pos) == i) hdr_one = hdr_bits[i];
        rd_addr = '0;
        if (int'(cur_pos) < HDR_LEN) begin
            rd_kind = hdr_one ? SK_HDR_HI : SK_HDR_LO;
        end else begin
            rd_kind = SK_STRIP;
            rd_addr = PAT_AW'(int'(cur_frame) * N_STRIPS + int'(cur_pos) - HDR_LEN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            for (int c = 0; c < N_CH; c++) begin
                pos[c]     <= '0;
                pidx[c]    <= '0;
                frame_q[c] <= '0;
            end
        end else begin
            slot          <= (slot == SLOT_W'(N_CH - 1)) ? '0 : slot + 1'b1;
            frame_q[slot] <= cur_frame;
            if (cur_pos == POS_W'(FRAME_LEN - 1)) begin
                pos[slot]  <= '0;
                pidx[slot] <= (pidx[slot] == PTR_AW'(PTR_DEPTH - 1)) ? '0 : pidx[slot] + 1'b1;
            end else begin
                pos[slot] <= cur_pos + 1'b1;
            end
        end
    end

    assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_W'(N_CH - 1)) |=> (slot == '0));

    assert_strip_in_store_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_kind == SK_STRIP) |-> (int'(rd_addr) < N_FRAMES * N_STRIPS));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        assert_pos_hold_R1: assert property (@(posedge clk) disable iff (rst)
            (slot != SLOT_W'(c)) |=> $stable(pos[c]));
        assert_frame_hold_R4: assert property (@(posedge clk) disable iff (rst)
            !(slot == SLOT_W'(c) && pos[c] == '0) |=> $stable(frame_q[c]));
        assert_entry_hold_R3: assert property (@(posedge clk) disable iff (rst)
            !(slot == SLOT_W'(c) && pos[c] == POS_W'(FRAME_LEN - 1)) |=> $stable(pidx[c]));
    end
endmodule

// File: rtl/fpg_patmem.sv
module fpg_patmem import fpg_pkg::*; #(
    parameter int N_WORDS = 2048,
    localparam int AW = $clog2(N_WORDS)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  logic [AW-1:0] waddr,
    input  dac_t      wdata,
    input  smp_kind_e rd_kind,
    input  logic [AW-1:0] rd_addr,
    input  dac_t      hdr_hi,
    input  dac_t      hdr_lo,
    output dac_t      smp
);
    dac_t      mem [N_WORDS];
    dac_t      rd_q;
    smp_kind_e kind_q;

    // One read and one write port per cycle; a colliding read sees the old word.
    always_ff @(posedge clk) begin
        if (we && int'(waddr) < N_WORDS)
            mem[waddr] <= wdata;
        rd_q <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) kind_q <= SK_NONE;
        else     kind_q <= rd_kind;
    end

    always_comb begin
        unique case (kind_q)
            SK_HDR_HI: smp = hdr_hi;
            SK_HDR_LO: smp = hdr_lo;
            SK_STRIP:  smp = rd_q;
            default:   smp = '0;
        endcase
    end
endmodule

// File: rtl/fpg_outstage.sv
module fpg_outstage import fpg_pkg::*; #(
    parameter int N_CH    = 6,
    parameter int MAX_DLY = 32,
    localparam int SLOT_W = $clog2(N_CH),
    localparam int N_OUT  = N_CH / 2,
    localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SLOT_W-1:0]        slot,
    input  dac_t                     smp,
    input  logic [N_OUT*DLY_W-1:0]   dly_cfg,
    output logic [N_OUT*DAC_W-1:0]   out_codes
);
    dac_t smp_q  [N_CH];
    dac_t odd_q  [N_OUT];
    dac_t pair_q [N_OUT];
    dac_t sr     [N_OUT][MAX_DLY];

    logic [SLOT_W-1:0] prev_slot;
    logic              ld_even, ld_odd;

    assign prev_slot = (slot == '0) ? SLOT_W'(N_CH - 1) : slot - 1'b1;
    assign ld_even   = (slot == SLOT_W'(1));
    assign ld_odd    = (slot == SLOT_W'(1 + N_OUT));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N_CH; c++) smp_q[c] <= '0;
            for (int p = 0; p < N_OUT; p++) begin
                odd_q[p]  <= '0;
                pair_q[p] <= '0;
                for (int i = 0; i < MAX_DLY; i++) sr[p][i] <= '0;
            end
        end else begin
            smp_q[prev_slot] <= smp;
            for (int p = 0; p < N_OUT; p++) begin
                if (ld_even) begin
                    pair_q[p] <= smp_q[2*p];
                    odd_q[p]  <= smp_q[2*p+1];
                end else if (ld_odd) begin
                    pair_q[p] <= odd_q[p];
                end
                if (ld_even || ld_odd) begin
                    sr[p][0] <= pair_q[p];
                    for (int i = 1; i < MAX_DLY; i++) sr[p][i] <= sr[p][i-1];
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < N_OUT; p++) begin
            int   d;
            dac_t o;
            d = clamp_dly(int'(dly_cfg[p*DLY_W +: DLY_W]), MAX_DLY);
            o = pair_q[p];
            for (int i = 0; i < MAX_DLY; i++)
                if (d == i + 1) o = sr[p][i];
            out_codes[p*DAC_W +: DAC_W] = o;
        end
    end

    for (genvar p = 0; p < N_OUT; p++) begin : g_chk
        assert_pair_hold_R6: assert property (@(posedge clk) disable iff (rst)
            !(ld_even || ld_odd) |=> $stable(pair_q[p]));
        assert_line_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !(ld_even || ld_odd) |=> $stable(sr[p][0]));
    end
endmodule

// File: rtl/frame_pattern_gen.sv
module frame_pattern_gen import fpg_pkg::*; #(
    parameter int N_CH      = 6,
    parameter int N_FRAMES  = 16,
    parameter int N_STRIPS  = 128,
    parameter int HDR_LEN   = 12,
    parameter int PTR_DEPTH = 256,
    parameter int MAX_DLY   = 32,
    localparam int PAT_WORDS = N_FRAMES * N_STRIPS,
    localparam int PAT_AW    = $clog2(PAT_WORDS),
    localparam int PTR_AW    = $clog2(PTR_DEPTH),
    localparam int ADDR_W    = (PAT_AW > PTR_AW) ? PAT_AW : PTR_AW,
    localparam int TGT_W     = $clog2(N_CH + 1),
    localparam int SLOT_W    = $clog2(N_CH),
    localparam int PV_W      = $clog2(N_FRAMES + 1),
    localparam int N_OUT     = N_CH / 2,
    localparam int DLY_W     = $clog2(MAX_DLY + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [TGT_W-1:0]       wr_tgt,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DAC_W-1:0]       wr_data,
    input  logic [DAC_W-1:0]       hdr_hi,
    input  logic [DAC_W-1:0]       hdr_lo,
    input  logic [HDR_LEN-1:0]     hdr_bits,
    input  logic [N_OUT*DLY_W-1:0] dly_cfg,
    output logic [N_OUT*DAC_W-1:0] out_codes
);
    logic [SLOT_W-1:0] slot;
    smp_kind_e         rd_kind;
    logic [PAT_AW-1:0] rd_addr;
    dac_t              smp;
    logic              pat_we, ptr_we;
    logic [SLOT_W-1:0] ptr_ch;

    assign pat_we = wr_en && (wr_tgt == '0);
    assign ptr_we = wr_en && (wr_tgt != '0);
    assign ptr_ch = SLOT_W'(wr_tgt - 1'b1);

    fpg_seq #(
        .N_CH(N_CH), .N_FRAMES(N_FRAMES), .N_STRIPS(N_STRIPS),
        .HDR_LEN(HDR_LEN), .PTR_DEPTH(PTR_DEPTH)
    ) u_seq (
        .clk(clk), .rst(rst),
        .ptr_we(ptr_we), .ptr_ch(ptr_ch),
        .ptr_addr(wr_addr[PTR_AW-1:0]), .ptr_val(wr_data[PV_W-1:0]),
        .hdr_bits(hdr_bits),
        .slot(slot), .rd_kind(rd_kind), .rd_addr(rd_addr)
    );

    fpg_patmem #(.N_WORDS(PAT_WORDS)) u_mem (
        .clk(clk), .rst(rst),
        .we(pat_we), .waddr(wr_addr[PAT_AW-1:0]), .wdata(wr_data),
        .rd_kind(rd_kind), .rd_addr(rd_addr),
        .hdr_hi(hdr_hi), .hdr_lo(hdr_lo),
        .smp(smp)
    );

    fpg_outstage #(.N_CH(N_CH), .MAX_DLY(MAX_DLY)) u_out (
        .clk(clk), .rst(rst), .slot(slot), .smp(smp),
        .dly_cfg(dly_cfg), .out_codes(out_codes)
    );
endmodule

// File: tb/frame_pattern_gen_test.sv
module frame_pattern_gen_test;
    localparam int N_CH = 6, N_FRAMES = 6, N_STRIPS = 8, HDR_LEN = 4, PTR_DEPTH = 4, MAX_DLY = 32;
    localparam int PAT_WORDS = N_FRAMES * N_STRIPS;
    localparam int FRAME_LEN = HDR_LEN + N_STRIPS;
    localparam int N_OUT = N_CH / 2;
    localparam int PV_MASK = 7;
    localparam int HI = 'hE21, LO = 'h10C;
    localparam logic [HDR_LEN-1:0] HBITS = 4'b1101;

    logic        clk = 0, rst = 1, wr_en = 0;
    logic [2:0]  wr_tgt = 0;
    logic [5:0]  wr_addr = 0;
    logic [11:0] wr_data = 0;
    logic [N_OUT*6-1:0]  dly_cfg;
    logic [N_OUT*12-1:0] out_codes;
    int dcfg [N_OUT];

    assign dly_cfg = {6'(dcfg[2]), 6'(dcfg[1]), 6'(dcfg[0])};

    frame_pattern_gen #(
        .N_CH(N_CH), .N_FRAMES(N_FRAMES), .N_STRIPS(N_STRIPS),
        .HDR_LEN(HDR_LEN), .PTR_DEPTH(PTR_DEPTH), .MAX_DLY(MAX_DLY)
    ) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
        .wr_data(wr_data), .hdr_hi(12'(HI)), .hdr_lo(12'(LO)), .hdr_bits(HBITS),
        .dly_cfg(dly_cfg), .out_codes(out_codes)
    );

    always #5 clk = ~clk;

    // Behavioural reference: memory images, channel cursors, sample history.
    int pat_m [PAT_WORDS];
    int ptr_m [N_CH][PTR_DEPTH];
    int m_pos [N_CH], m_ent [N_CH], m_frm [N_CH];
    int hist [N_CH][$];
    int edge_no = 0, cmp_n = 0, err_n = 0;
    bit cmp_on = 0, done = 0;
    string tag = "R10";

    initial for (int c = 0; c < N_CH; c++) begin
        m_pos[c] = 0; m_ent[c] = 0; m_frm[c] = 0;
    end

    always @(posedge clk) begin
        if (!rst) begin
            int c, s;
            c = edge_no % N_CH;
            if (m_pos[c] == 0) begin
                m_frm[c] = ptr_m[c][m_ent[c]];
                if (m_frm[c] >= N_FRAMES) m_frm[c] = 0;
            end
            if (m_pos[c] < HDR_LEN) s = HBITS[m_pos[c]] ? HI : LO;
            else                    s = pat_m[m_frm[c] * N_STRIPS + m_pos[c] - HDR_LEN];
            hist[c].push_back(s);
            m_pos[c]++;
            if (m_pos[c] == FRAME_LEN) begin
                m_pos[c] = 0;
                m_ent[c] = (m_ent[c] + 1) % PTR_DEPTH;
            end
            edge_no++;
        end
        if (wr_en) begin
            if (wr_tgt == 0) pat_m[int'(wr_addr)] = int'(wr_data);
            else ptr_m[int'(wr_tgt) - 1][int'(wr_addr) % PTR_DEPTH] = int'(wr_data) & PV_MASK;
        end
    end

    function automatic int exp_out(int p);
        int e, kk, r, n, j;
        e = edge_no - 1;
        if (e < 0) return 0;
        kk = e / N_CH; r = e % N_CH;
        if (r >= 1 + N_OUT)  n = 2 * kk - 1;
        else if (r >= 1)     n = 2 * kk - 2;
        else                 n = 2 * kk - 3;
        j = n - ((dcfg[p] > MAX_DLY) ? MAX_DLY : dcfg[p]);
        if (j < 0) return 0;
        return (j % 2 == 0) ? hist[2*p][j/2] : hist[2*p+1][j/2];
    endfunction

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int p = 0; p < N_OUT; p++) begin
                int ex;
                logic [11:0] got;
                got = out_codes[p*12 +: 12];
                ex = exp_out(p);
                cmp_n++;
                if ($isunknown(got) || int'(got) != ex) begin
                    err_n++;
                    $display("FAIL %s out%0d edge %0d: actual %0h expected %0h", tag, p, edge_no, got, ex);
                end
            end
        end
    end

    task automatic hwrite(int tgt, int addr, int data);
        @(posedge clk); #2;
        wr_en = 1; wr_tgt = 3'(tgt); wr_addr = 6'(addr); wr_data = 12'(data);
    endtask

    task automatic idle(int n);
        @(posedge clk); #2; wr_en = 0;
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, err_n);
    endtask

    initial begin
        dcfg[0] = 0; dcfg[1] = 3; dcfg[2] = 32;
        repeat (2) @(posedge clk);
        #2 cmp_on = 1;
        // R10 and R9: store fill while held in reset, outputs must stay 0.
        tag = "R10 R9 reset";
        for (int i = 0; i < PAT_WORDS; i++) hwrite(0, i, (i * 37 + 5) & 'hFFF);
        for (int c = 0; c < N_CH; c++)
            for (int j = 0; j < PTR_DEPTH; j++) hwrite(c + 1, j, (c * 3 + j * 5) % 8);
        idle(3);
        #2 rst = 0;
        // R1 R2 R3 R5 R6 R7 R11: steady playback through several list wraps.
        tag = "R1 R2 R3 R5 R6 R7 R11 playback";
        repeat (700) @(posedge clk);
        // R4 R9: back-to-back writes collide with live reads and frame starts.
        tag = "R4 R9 live-write";
        for (int i = 0; i < 400; i++) begin
            int t;
            t = $urandom_range(0, N_CH);
            hwrite(t, (t == 0) ? $urandom_range(0, PAT_WORDS - 1) : $urandom_range(0, PTR_DEPTH - 1),
                   $urandom_range(0, 4095));
        end
        tag = "R3 R4 R9 after-write";
        idle(300);
        // R8: new depths, one above the limit.
        @(posedge clk); #2;
        dcfg[0] = 5; dcfg[1] = 32; dcfg[2] = 45;
        tag = "R8 delay";
        repeat (400) @(posedge clk);
        #1 done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            cmp_n++; err_n++;
            $display("FAIL watchdog R1: actual hung expected finish");
            summary();
            $finish;
        end
    end
endmodule